// File: doc/BRIEF.md
# Biased 8-bit Convolution Multiply-Accumulate Array

This block runs one convolution step of an image tile against a group of filter vectors and folds the result into an array of 8 rows by 8 columns of 32-bit accumulators. The image side is eight 256-bit vectors presented together as one tile of 8 rows by 32 bytes. The filter side is up to eight 256-bit vectors. A 32-bit command word chooses which 32-bit word positions of the image rows take part (a first and a last index). It also carries a signed 9-bit offset for each operand and a flag per operand that says whether its bytes are signed. Each offset is added to its operand before the multiply.

A command is requested with a one-cycle `cmdValid` pulse. A command that fails the legality checks is refused: a one-cycle `illegal` pulse follows and the accumulators are left alone. A legal command makes the block busy for one cycle per selected word index. In each of those cycles it performs 256 byte multiplies in parallel. A one-cycle `done` pulse marks completion. Results are placed in an interleaved quad layout, not in plain matrix order, so a later reduction step must reorder them. A clear input zeroes the array. A combinational read port returns one accumulator row per address.

Top module: `conv_mac_array`

## Requirements
- R1: `cmdWord` is decoded as follows: bit 0 is the filter-signed flag, bits 9:1 are the filter offset, bit 10 is the image-signed flag, bits 19:11 are the image offset, bits 24:20 are the last index, bits 29:25 are the first index, and bits 31:30 are the mode.
- R2: A command with a nonzero mode raises `illegal` for one cycle, in the cycle after the request. It never raises `busy` and leaves every accumulator unchanged.
- R3: A command whose first index exceeds its last index, or whose first or last index is 8 or more, is refused in the same way as in R2.
- R4: Both offsets are 9-bit two's-complement values. An image or filter byte is read as a signed value when its flag is 1, and as an unsigned value (0..255) when its flag is 0.
- R5: For each index k from first to last, filter vector (k − first) is used. Image row i, byte j (j = 0..31) pairs image byte 4k + (j mod 4) with filter byte j.
- R6: The product (image + imageOffset) × (filter + filterOffset) from image row i and filter byte j is added to accumulator row (i − i mod 4) + q[(j/4) mod 4], column (i mod 4)·2 + (j/4)/4, where q = {0,2,1,3}.
- R7: Products add onto the existing accumulator contents across commands. The additions wrap modulo 2^32 with no saturation.
- R8: A legal command asserts `busy` from the cycle after the request for exactly (last − first + 1) cycles. `done` pulses for one cycle as `busy` falls. `cmdValid` is ignored while `busy` is high.
- R9: `clearAcc` zeroes every accumulator at the next clock edge. When a clear and an accumulate fall on the same edge, the clear wins.
- R10: `rdRow` shows accumulator row `rdAddr` combinationally, with column c in bits 32c+31:32c. All accumulators read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle command request |
| cmdWord | input | 32 | Command word, decoded per R1 |
| narrowData | input | 2048 | Image tile; row i byte j at bits 8(32i+j)+7:8(32i+j). Must be held while busy |
| wideData | input | 2048 | Filter vectors; vector m byte j at bits 8(32m+j)+7:8(32m+j). Must be held while busy |
| clearAcc | input | 1 | Zero all accumulators |
| rdAddr | input | 3 | Accumulator row to read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle refusal pulse |
| rdRow | output | 256 | Accumulator row `rdAddr`, column c at bits 32c+31:32c |

## Verification
A wrong lane wiring, a wrong byte choice, or a wrong offset or sign extension shows up as an exact value mismatch in particular accumulator rows and columns. These can be read on `rdRow` the cycle after `done` rises, so every legal command in the sweep is followed by a full read of the array. A faulty index counter shows up in the same cycle as a wrong busy length or a missing `done`. A faulty legality decision shows up on `illegal` one cycle after the request, and as accumulators that change when they should not. Long runs of maximum products expose carry or wrap faults in the accumulator adders.

// File: rtl/conv_mac_pkg.sv
package conv_mac_pkg;

  // Command word, most significant field first.
  typedef struct packed {
    logic [1:0] mode;
    logic [4:0] firstIdx;
    logic [4:0] lastIdx;
    logic [8:0] imgOffset;
    logic       imgSigned;
    logic [8:0] fltOffset;
    logic       fltSigned;
  } convCmd_t;

  // Strobes and configuration passed from control to datapath.
  typedef struct packed {
    logic       accEn;
    logic       clrEn;
    logic [4:0] kIdx;
    logic [4:0] wideIdx;
    logic       imgSigned;
    logic       fltSigned;
    logic [8:0] imgOffset;
    logic [8:0] fltOffset;
  } convStrobe_t;

  // Row slot within a quad for a given word position modulo 4 (self-inverse).
  function automatic int quadSlot(input int q);
    case (q)
      1:       return 2;
      2:       return 1;
      default: return q;
    endcase
  endfunction

  // Extend a data byte and add its 9-bit signed offset.
  function automatic logic signed [10:0] biasedOperand(input logic [7:0] data,
                                                       input logic isSigned,
                                                       input logic [8:0] offset);
    logic signed [10:0] dataExt;
    logic signed [10:0] offExt;
    dataExt = isSigned ? {{3{data[7]}}, data} : {3'b000, data};
    offExt  = {{2{offset[8]}}, offset};
    return dataExt + offExt;
  endfunction

endpackage

// File: rtl/conv_mac_dot4.sv
module conv_mac_dot4
  import conv_mac_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic [31:0]      narrowWord,
  input  logic [31:0]      wideWord,
  input  logic             imgSigned,
  input  logic             fltSigned,
  input  logic [8:0]       imgOffset,
  input  logic [8:0]       fltOffset,
  output logic [ACC_W-1:0] dotSum
);

  logic signed [23:0] partial;

  always_comb begin
    logic signed [10:0] opA;
    logic signed [10:0] opB;
    partial = '0;
    for (int b = 0; b < 4; b++) begin
      opA = biasedOperand(narrowWord[8*b +: 8], imgSigned, imgOffset);
      opB = biasedOperand(wideWord[8*b +: 8], fltSigned, fltOffset);
      partial = partial + (24'(opA) * 24'(opB));
    end
  end

  assign dotSum = ACC_W'(partial);

endmodule

// File: rtl/conv_mac_ctrl.sv
module conv_mac_ctrl
  import conv_mac_pkg::*;
#(
  parameter int NUM_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [31:0] cmdWord,
  input  logic        clearAcc,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output convStrobe_t strobe
);

  convCmd_t   dec;
  logic       cmdLegal;
  logic       busyQ, doneQ, illegalQ;
  logic [4:0] kQ, startQ, stopQ;
  logic [8:0] imgOffQ, fltOffQ;
  logic       imgSgnQ, fltSgnQ;

  assign dec = convCmd_t'(cmdWord);

  always_comb begin
    cmdLegal = (dec.mode == 2'b00)
            && (dec.firstIdx <= dec.lastIdx)
            && (int'(dec.firstIdx) < NUM_WORDS)
            && (int'(dec.lastIdx) < NUM_WORDS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
      illegalQ <= 1'b0;
      kQ       <= '0;
      startQ   <= '0;
      stopQ    <= '0;
      imgOffQ  <= '0;
      fltOffQ  <= '0;
      imgSgnQ  <= 1'b0;
      fltSgnQ  <= 1'b0;
    end else begin
      doneQ    <= 1'b0;
      illegalQ <= 1'b0;
      if (busyQ) begin
        if (kQ == stopQ) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          kQ <= kQ + 5'd1;
        end
      end else if (cmdValid) begin
        if (cmdLegal) begin
          busyQ   <= 1'b1;
          kQ      <= dec.firstIdx;
          startQ  <= dec.firstIdx;
          stopQ   <= dec.lastIdx;
          imgOffQ <= dec.imgOffset;
          fltOffQ <= dec.fltOffset;
          imgSgnQ <= dec.imgSigned;
          fltSgnQ <= dec.fltSigned;
        end else begin
          illegalQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.accEn     = busyQ;
    strobe.clrEn     = clearAcc;
    strobe.kIdx      = kQ;
    strobe.wideIdx   = kQ - startQ;
    strobe.imgSigned = imgSgnQ;
    strobe.fltSigned = fltSgnQ;
    strobe.imgOffset = imgOffQ;
    strobe.fltOffset = fltOffQ;
  end

  assign busy    = busyQ;
  assign done    = doneQ;
  assign illegal = illegalQ;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> ($past(busyQ) && !busyQ));

  // R2 R3
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalQ |-> (!busyQ && !doneQ));

  // R5
  k_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> ((kQ >= startQ) && (kQ <= stopQ) && (int'(stopQ) < NUM_WORDS)));

  // R8
  k_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && (kQ != stopQ)) |=> (busyQ && (kQ == $past(kQ) + 5'd1)));

endmodule

// File: rtl/conv_mac_datapath.sv
module conv_mac_datapath
  import conv_mac_pkg::*;
#(
  parameter int NUM_ROWS  = 8,
  parameter int NUM_WORDS = 8,
  parameter int ACC_W     = 32,
  localparam int VEC_BYTES     = 4 * NUM_WORDS,
  localparam int COLS_PER_QUAD = NUM_WORDS / 4,
  localparam int NARROW_W      = NUM_ROWS * VEC_BYTES * 8,
  localparam int WIDE_W        = NUM_WORDS * VEC_BYTES * 8,
  localparam int RA_W          = $clog2(NUM_ROWS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  convStrobe_t                   strobe,
  input  logic [NARROW_W-1:0]           narrowData,
  input  logic [WIDE_W-1:0]             wideData,
  input  logic [RA_W-1:0]               rdAddr,
  output logic [NUM_WORDS*ACC_W-1:0]    rdRow
);

  logic [NUM_ROWS-1:0][NUM_WORDS-1:0][ACC_W-1:0] accQ;
  logic [NUM_ROWS-1:0][NUM_WORDS-1:0][ACC_W-1:0] dotArr;

  // Each accumulator owns one image row and one filter word position.
  for (genvar gr = 0; gr < NUM_ROWS; gr++) begin : g_row
    for (genvar gc = 0; gc < NUM_WORDS; gc++) begin : g_col
      localparam int SRC_ROW  = (gr / 4) * 4 + gc / COLS_PER_QUAD;
      localparam int SRC_WORD = (gc % COLS_PER_QUAD) * 4 + quadSlot(gr % 4);
      logic [31:0] nWord;
      logic [31:0] wWord;
      assign nWord = narrowData[(SRC_ROW * VEC_BYTES + 4 * int'(strobe.kIdx)) * 8 +: 32];
      assign wWord = wideData[(int'(strobe.wideIdx) * VEC_BYTES + 4 * SRC_WORD) * 8 +: 32];
      conv_mac_dot4 #(.ACC_W(ACC_W)) i_dot (
        .narrowWord(nWord),
        .wideWord  (wWord),
        .imgSigned (strobe.imgSigned),
        .fltSigned (strobe.fltSigned),
        .imgOffset (strobe.imgOffset),
        .fltOffset (strobe.fltOffset),
        .dotSum    (dotArr[gr][gc])
      );
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (strobe.clrEn) begin
      accQ <= '0;
    end else if (strobe.accEn) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        for (int c = 0; c < NUM_WORDS; c++) begin
          accQ[r][c] <= accQ[r][c] + dotArr[r][c];
        end
      end
    end
  end

  assign rdRow = accQ[rdAddr];

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEn |=> (accQ == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.accEn && !strobe.clrEn) |=> $stable(accQ));

endmodule

// File: rtl/conv_mac_array.sv
module conv_mac_array
  import conv_mac_pkg::*;
#(
  parameter int NUM_ROWS  = 8,
  parameter int NUM_WORDS = 8,
  parameter int ACC_W     = 32,
  localparam int VEC_BYTES = 4 * NUM_WORDS,
  localparam int NARROW_W  = NUM_ROWS * VEC_BYTES * 8,
  localparam int WIDE_W    = NUM_WORDS * VEC_BYTES * 8,
  localparam int RA_W      = $clog2(NUM_ROWS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic [31:0]                cmdWord,
  input  logic [NARROW_W-1:0]        narrowData,
  input  logic [WIDE_W-1:0]          wideData,
  input  logic                       clearAcc,
  input  logic [RA_W-1:0]            rdAddr,
  output logic                       busy,
  output logic                       done,
  output logic                       illegal,
  output logic [NUM_WORDS*ACC_W-1:0] rdRow
);

  convStrobe_t strobe;

  conv_mac_ctrl #(.NUM_WORDS(NUM_WORDS)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdWord (cmdWord),
    .clearAcc(clearAcc),
    .busy    (busy),
    .done    (done),
    .illegal (illegal),
    .strobe  (strobe)
  );

  conv_mac_datapath #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_WORDS(NUM_WORDS),
    .ACC_W    (ACC_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .narrowData(narrowData),
    .wideData  (wideData),
    .rdAddr    (rdAddr),
    .rdRow     (rdRow)
  );

endmodule

// File: tb/test_conv_mac_array.sv
module test_conv_mac_array;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int NW = 8;
  localparam int VB = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdValid = 1'b0;
  logic [31:0]     cmdWord = '0;
  logic [NR*VB*8-1:0] narrowData = '0;
  logic [NW*VB*8-1:0] wideData = '0;
  logic            clearAcc = 1'b0;
  logic [2:0]      rdAddr = '0;
  logic            busy, done, illegal;
  logic [NW*32-1:0] rdRow;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0]  nb [NR][VB];
  logic [7:0]  wb [NW][VB];
  logic [31:0] model [NR][NW];

  conv_mac_array i_conv_mac_array (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .narrowData(narrowData), .wideData(wideData), .clearAcc(clearAcc),
    .rdAddr(rdAddr), .busy(busy), .done(done), .illegal(illegal), .rdRow(rdRow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic packData();
    for (int i = 0; i < NR; i++)
      for (int j = 0; j < VB; j++) narrowData[(i*VB+j)*8 +: 8] = nb[i][j];
    for (int m = 0; m < NW; m++)
      for (int j = 0; j < VB; j++) wideData[(m*VB+j)*8 +: 8] = wb[m][j];
  endtask

  task automatic fillRandom();
    for (int i = 0; i < NR; i++)
      for (int j = 0; j < VB; j++) nb[i][j] = 8'($urandom);
    for (int m = 0; m < NW; m++)
      for (int j = 0; j < VB; j++) wb[m][j] = 8'($urandom);
    packData();
  endtask

  task automatic modelClear();
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NW; c++) model[r][c] = '0;
  endtask

  // Reference built straight from the placement rule (R5, R6).
  task automatic modelApply(input logic [31:0] cmd);
    int st, sp, b1, b2;
    st = int'(cmd[29:25]);
    sp = int'(cmd[24:20]);
    b1 = cmd[19] ? int'(cmd[19:11]) - 512 : int'(cmd[19:11]);
    b2 = cmd[9] ? int'(cmd[9:1]) - 512 : int'(cmd[9:1]);
    for (int k = st; k <= sp; k++)
      for (int i = 0; i < NR; i++)
        for (int j = 0; j < VB; j++) begin
          int n, w, wq, slot, row, col;
          n = int'(nb[i][4*k + j%4]);
          if (cmd[10] && n > 127) n = n - 256;
          w = int'(wb[k-st][j]);
          if (cmd[0] && w > 127) w = w - 256;
          wq = j / 4;
          slot = (wq % 4 == 1) ? 2 : (wq % 4 == 2) ? 1 : wq % 4;
          row = (i / 4) * 4 + slot;
          col = (i % 4) * 2 + wq / 4;
          model[row][col] = model[row][col] + 32'((n + b1) * (w + b2));
        end
  endtask

  task automatic compareAll(input string req);
    logic [255:0] exp;
    for (int r = 0; r < NR; r++) begin
      rdAddr = 3'(r);
      #1;
      for (int c = 0; c < NW; c++) exp[c*32 +: 32] = model[r][c];
      check(rdRow === exp, req, $sformatf("accumulator row %0d", r), rdRow, exp);
    end
  endtask

  task automatic runCmd(input logic [31:0] cmd, input bit expIllegal,
                        input string req, input bit pokeBusy);
    int cnt;
    bit sawIllegal;
    cnt = 0;
    sawIllegal = 0;
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord = cmd;
    @(negedge clk);
    cmdValid = 1'b0;
    check(illegal === expIllegal, req, "illegal pulse", 256'(illegal), 256'(expIllegal));
    check(busy === !expIllegal, req, "busy after request", 256'(busy), 256'(!expIllegal));
    if (expIllegal) begin
      @(negedge clk);
      check(illegal === 1'b0 && busy === 1'b0, req, "illegal one cycle, no busy",
            256'({illegal, busy}), 256'(0));
      return;
    end
    while (busy === 1'b1 && cnt < 40) begin
      cnt++;
      if (illegal === 1'b1) sawIllegal = 1;
      if (pokeBusy && cnt == 1) begin
        cmdValid = 1'b1;
        cmdWord = 32'h4000_0000;
      end else begin
        cmdValid = 1'b0;
      end
      @(negedge clk);
    end
    cmdValid = 1'b0;
    if (illegal === 1'b1) sawIllegal = 1;
    check(cnt == int'(cmd[24:20]) - int'(cmd[29:25]) + 1, "R8", "busy length",
          256'(cnt), 256'(int'(cmd[24:20]) - int'(cmd[29:25]) + 1));
    check(done === 1'b1, "R8", "done as busy falls", 256'(done), 256'(1));
    if (pokeBusy) begin
      @(negedge clk);
      check(!sawIllegal && illegal === 1'b0 && busy === 1'b0 && done === 1'b0, "R8",
            "request while busy ignored", 256'({sawIllegal, illegal, busy, done}), 256'(0));
    end
    modelApply(cmd);
  endtask

  function automatic logic [31:0] mkCmd(input int mode, input int st, input int sp,
                                        input logic [8:0] b1, input logic s1,
                                        input logic [8:0] b2, input logic s2);
    return {2'(mode), 5'(st), 5'(sp), b1, s1, b2, s2};
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    logic [8:0] offs [4];
    offs[0] = 9'h100; offs[1] = 9'h0FF; offs[2] = 9'h000; offs[3] = 9'h1FF;
    modelClear();
    fillRandom();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(busy === 1'b0 && done === 1'b0 && illegal === 1'b0, "R10", "idle outputs after reset",
          256'({busy, done, illegal}), 256'(0));
    compareAll("R10");

    // R3 R5 R6: sweep of first/last index pairs
    for (int s = 0; s < 10; s++) begin
      fillRandom();
      for (int p = 0; p < 10; p++) begin
        bit leg;
        logic [31:0] cmd;
        leg = (s <= p) && (p < NW);
        cmd = mkCmd(0, s, p, 9'(s*37 + p*11), 1'((s+p) % 2), 9'(300 - s*19 - p*5), 1'((s+p)/2 % 2));
        runCmd(cmd, !leg, leg ? "R5" : "R3", 0);
        compareAll(leg ? "R6" : "R3");
      end
    end

    // R1 R4: offset extremes with every sign-flag combination
    for (int f = 0; f < 4; f++)
      for (int o = 0; o < 4; o++) begin
        fillRandom();
        runCmd(mkCmd(0, 2, 5, offs[o], 1'(f[0]), offs[3-o], 1'(f[1])), 0, "R4", 0);
        compareAll("R1/R4");
      end

    // R2: nonzero modes refused
    for (int m = 1; m < 4; m++) begin
      runCmd(mkCmd(m, 0, 7, 9'h055, 1'b0, 9'h0BC, 1'b1), 1, "R2", 0);
      compareAll("R2");
    end

    // R8: a request during busy is ignored
    runCmd(mkCmd(0, 1, 6, 9'h1F0, 1'b1, 9'h010, 1'b0), 0, "R8", 1);
    compareAll("R8");

    // R9: clear while idle
    @(negedge clk);
    clearAcc = 1'b1;
    @(negedge clk);
    clearAcc = 1'b0;
    modelClear();
    compareAll("R9");

    // R9: clear and accumulate on the same edge, clear wins
    fillRandom();
    runCmd(mkCmd(0, 0, 3, 9'h021, 1'b0, 9'h033, 1'b0), 0, "R9", 0);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord = mkCmd(0, 4, 4, 9'h0FF, 1'b0, 9'h0FF, 1'b0);
    @(negedge clk);
    cmdValid = 1'b0;
    clearAcc = 1'b1;
    @(negedge clk);
    clearAcc = 1'b0;
    check(done === 1'b1, "R9", "done with clear on last cycle", 256'(done), 256'(1));
    modelClear();
    compareAll("R9");

    // R7: long accumulation past 2^32 with maximal products
    for (int i = 0; i < NR; i++) for (int j = 0; j < VB; j++) nb[i][j] = 8'hFF;
    for (int m = 0; m < NW; m++) for (int j = 0; j < VB; j++) wb[m][j] = 8'hFF;
    packData();
    for (int n = 0; n < 520; n++) begin
      @(negedge clk);
      cmdValid = 1'b1;
      cmdWord = mkCmd(0, 0, 7, 9'h0FF, 1'b0, 9'h0FF, 1'b0);
      @(negedge clk);
      cmdValid = 1'b0;
      while (busy === 1'b1) @(negedge clk);
      modelApply(mkCmd(0, 0, 7, 9'h0FF, 1'b0, 9'h0FF, 1'b0));
    end
    compareAll("R7");
    rdAddr = 3'd5;
    #1;
    check(rdRow[3*32 +: 32] === 32'(64'd8323200 * 64'd520), "R7", "wrapped sum",
          256'(rdRow[3*32 +: 32]), 256'(32'(64'd8323200 * 64'd520)));

    finish();
  end

endmodule